// File: doc/BRIEF.md
# Bidirectional Bus Transceiver Channel Array

This block joins two parallel buses, side A and side B, through a bank of storage cells. It has one cell per bit for each direction. Each direction has four controls. The latch enable is active high. The clock enable and the output enable are active low. The fourth is a slow per-direction transfer clock. From these the direction picks one of four behaviours on each system clock cycle:

- follow the source bus transparently,
- hold the stored word while the transfer clock sits still,
- capture the source bus on a rising transfer-clock edge,
- ignore transfer-clock edges completely.

The stored word (or, when transparent, the live source word) is driven onto the opposite bus only while that direction's output enable is asserted. Both data buses are tri-state inout ports.

The A-to-B transfer clock is forwarded out on the B side. A clock arriving on the B side is forwarded to the A side. Each forwarded clock is enabled by the output enable of its own direction.

Both output enables asserted together is not a supported operating state. The block raises a flag in that state and releases both data buses. All storage runs on one system clock. The transfer clocks are sampled as ordinary inputs, and their rising edges are detected inside the block. An optional synchronous reset clears the stored words.

Top module: `ubt_array`

## Requirements
- R1: With RESET_EN set, holding `rst` high through a rising `clk` edge clears both stored words to zero.
- R2: While a direction's latch enable is high, its output equals its source bus in the same cycle, with no clock edge needed. The stored word takes the source value on every `clk` edge. After the latch enable falls, the output keeps the value sampled at the last `clk` edge at which the latch enable was high.
- R3: With the latch enable low and the clock enable (active low) low, a transfer-clock level that is 1 at a `clk` edge, after being 0 at the previous edge, counts as a rising edge. At that `clk` edge the source bus is stored. The transfer clock must stay high and low for at least one `clk` cycle each.
- R4: With the latch enable low and the clock enable high, transfer-clock edges are ignored and the stored word does not change.
- R5: With the latch enable low, the clock enable low and the transfer clock steady (high or low), the stored word does not change. This also holds when the clock enable drops while the transfer clock is already high.
- R6: When `ab_oe_n` is low and `ba_oe_n` is high, `b_io` carries the A-to-B output. When `ab_oe_n` is high, the block does not drive `b_io`.
- R7: The B-to-A direction behaves as in R2 to R6. It uses `ba_le`, `ba_ce_n`, `ba_clk` and `ba_oe_n`, takes `b_io` as its source and drives `a_io`.
- R8: `b_clk_o` equals `ab_clk` while `ab_oe_n` is low, and is high-impedance otherwise. `a_clk_o` equals `b_clk_i` while `ba_oe_n` is low, and is high-impedance otherwise.
- R9: `contention` is 1 exactly when both output enables are low. In that state neither `a_io` nor `b_io` is driven by the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all storage |
| rst | input | 1 | Synchronous reset, active high |
| a_io | inout | WIDTH | A-side data bus |
| b_io | inout | WIDTH | B-side data bus |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, active high |
| ab_clk | input | 1 | A-to-B transfer clock, sampled by `clk` |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, active high |
| ba_clk | input | 1 | B-to-A transfer clock, sampled by `clk` |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| b_clk_i | input | 1 | Clock received on the B side |
| b_clk_o | output | 1 | Forwarded copy of `ab_clk` |
| a_clk_o | output | 1 | Forwarded copy of `b_clk_i` |
| contention | output | 1 | Both output enables asserted |

## Verification
The bench sweeps every combination of latch enable, clock enable and transfer-clock pulse in both directions, with fresh data each time.

It also targets four corner cases:

- **Latch enable falling.** A design that captured on the falling edge of the latch enable would show the newer source word instead of the last sampled one.
- **Clock enable dropping while the transfer clock is already high.** A design that treated a level as an edge would store the new data.
- **Disabled output driver.** The bench drives zeros onto a bus the block should have released. A block that still drove its nonzero stored word would corrupt the value read back.
- **Both output enables asserted.** A design without the release would drive both buses against the bench.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

   typedef enum logic [1:0] {
      UBT_FOLLOW  = 2'd0,
      UBT_HOLD    = 2'd1,
      UBT_CAPTURE = 2'd2,
      UBT_INHIBIT = 2'd3
   } ubt_mode_e;

   // Priority: latch enable first, then the clock-enable gate, then the edge.
   function automatic ubt_mode_e ubt_pick_mode(input logic le,
                                                input logic ce_n,
                                                input logic rise);
      if (le)
         return UBT_FOLLOW;
      else if (ce_n)
         return UBT_INHIBIT;
      else if (rise)
         return UBT_CAPTURE;
      else
         return UBT_HOLD;
   endfunction

endpackage

// File: rtl/ubt_edge.sv
module ubt_edge #(
   parameter bit RESET_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);

   logic prev_lvl;

   generate
      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst)
               prev_lvl <= 1'b0;
            else
               prev_lvl <= lvl;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            prev_lvl <= lvl;
         end
      end
   endgenerate

   assign rise = lvl & ~prev_lvl;

endmodule

// File: rtl/ubt_store.sv
module ubt_store
   import ubt_pkg::*;
#(
   parameter int WIDTH    = 17,
   parameter bit RESET_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   input  logic             le,
   input  logic             xfer_clk,
   input  logic             ce_n,
   output logic [WIDTH-1:0] dout
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ubt_store: WIDTH must be at least 1");
      end
   endgenerate

   logic             rise;
   ubt_mode_e        mode;
   logic [WIDTH-1:0] word_q;
   logic [WIDTH-1:0] word_d;

   ubt_edge #(.RESET_EN(RESET_EN)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (xfer_clk),
      .rise (rise)
   );

   always_comb begin
      mode = ubt_pick_mode(le, ce_n, rise);
      unique case (mode)
         UBT_FOLLOW, UBT_CAPTURE: word_d = din;
         default:                 word_d = word_q;
      endcase
   end

   generate
      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst)
               word_q <= '0;
            else
               word_q <= word_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            word_q <= word_d;
         end
      end
   endgenerate

   assign dout = le ? din : word_q;

   // R2: while transparent the cell tracks the source every cycle
   a_r2_follow: assert property (@(posedge clk) disable iff (rst)
      le |=> word_q == $past(din));

   // R3: a detected rising edge with the gate open stores the source
   a_r3_capture: assert property (@(posedge clk) disable iff (rst)
      (!le && !ce_n && rise) |=> word_q == $past(din));

   // R4: clock inhibit keeps the word
   a_r4_inhibit: assert property (@(posedge clk) disable iff (rst)
      (!le && ce_n) |=> word_q == $past(word_q));

   // R5: no edge, no change
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!le && !ce_n && !rise) |=> word_q == $past(word_q));

endmodule

// File: rtl/ubt_tri.sv
module ubt_tri #(
   parameter int WIDTH = 17
) (
   input  logic             en,
   input  logic [WIDTH-1:0] val,
   inout  wire  [WIDTH-1:0] pad
);

   assign pad = en ? val : {WIDTH{1'bz}};

endmodule

// File: rtl/ubt_array.sv
module ubt_array #(
   parameter int WIDTH    = 17,
   parameter bit RESET_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   inout  wire  [WIDTH-1:0] a_io,
   inout  wire  [WIDTH-1:0] b_io,
   input  logic             ab_oe_n,
   input  logic             ab_le,
   input  logic             ab_clk,
   input  logic             ab_ce_n,
   input  logic             ba_oe_n,
   input  logic             ba_le,
   input  logic             ba_clk,
   input  logic             ba_ce_n,
   input  logic             b_clk_i,
   output logic             b_clk_o,
   output logic             a_clk_o,
   output logic             contention
);

   generate
      if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
         $error("ubt_array: WIDTH out of range 1..1024");
      end
   endgenerate

   logic [WIDTH-1:0] ab_word;
   logic [WIDTH-1:0] ba_word;
   logic             drv_b;
   logic             drv_a;
   logic             both_on;

   assign both_on    = ~ab_oe_n & ~ba_oe_n;
   assign drv_b      = ~ab_oe_n & ~both_on;
   assign drv_a      = ~ba_oe_n & ~both_on;
   assign contention = both_on;

   ubt_store #(.WIDTH(WIDTH), .RESET_EN(RESET_EN)) u_ab (
      .clk      (clk),
      .rst      (rst),
      .din      (a_io),
      .le       (ab_le),
      .xfer_clk (ab_clk),
      .ce_n     (ab_ce_n),
      .dout     (ab_word)
   );

   ubt_store #(.WIDTH(WIDTH), .RESET_EN(RESET_EN)) u_ba (
      .clk      (clk),
      .rst      (rst),
      .din      (b_io),
      .le       (ba_le),
      .xfer_clk (ba_clk),
      .ce_n     (ba_ce_n),
      .dout     (ba_word)
   );

   ubt_tri #(.WIDTH(WIDTH)) u_drv_b (
      .en  (drv_b),
      .val (ab_word),
      .pad (b_io)
   );

   ubt_tri #(.WIDTH(WIDTH)) u_drv_a (
      .en  (drv_a),
      .val (ba_word),
      .pad (a_io)
   );

   assign b_clk_o = ab_oe_n ? 1'bz : ab_clk;
   assign a_clk_o = ba_oe_n ? 1'bz : b_clk_i;

   // R6 and R7: at most one side of the array drives at any time
   a_r6_one_driver: assert property (@(posedge clk) disable iff (rst)
      $onehot0({drv_a, drv_b}));

   // R9: the flag and the released buses go together
   a_r9_release: assert property (@(posedge clk) disable iff (rst)
      contention |-> (!drv_a && !drv_b));

endmodule

// File: tb/ubt_array_test.sv
module ubt_array_test;

   localparam int W          = 17;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst;
   logic ab_oe_n, ab_le, ab_clk, ab_ce_n;
   logic ba_oe_n, ba_le, ba_clk, ba_ce_n;
   logic b_clk_i;
   logic b_clk_o, a_clk_o, contention;

   logic         tb_a_en, tb_b_en;
   logic [W-1:0] tb_a_val, tb_b_val;
   wire  [W-1:0] a_io, b_io;

   assign a_io = tb_a_en ? tb_a_val : {W{1'bz}};
   assign b_io = tb_b_en ? tb_b_val : {W{1'bz}};

   int checks   = 0;
   int failures = 0;

   logic [W-1:0] exp_ab, exp_ba;

   always #(CLK_PERIOD/2) clk = ~clk;

   ubt_array #(.WIDTH(W), .RESET_EN(1'b1)) uut (
      .clk        (clk),
      .rst        (rst),
      .a_io       (a_io),
      .b_io       (b_io),
      .ab_oe_n    (ab_oe_n),
      .ab_le      (ab_le),
      .ab_clk     (ab_clk),
      .ab_ce_n    (ab_ce_n),
      .ba_oe_n    (ba_oe_n),
      .ba_le      (ba_le),
      .ba_clk     (ba_clk),
      .ba_ce_n    (ba_ce_n),
      .b_clk_i    (b_clk_i),
      .b_clk_o    (b_clk_o),
      .a_clk_o    (a_clk_o),
      .contention (contention)
   );

   task automatic chk(input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // One A-to-B case: returns after the block has settled
   task automatic case_ab(input logic [W-1:0] d, input logic le,
                          input logic ce_n, input logic pulse);
      @(negedge clk);
      tb_a_en = 1'b1; tb_a_val = d;
      ab_le = le; ab_ce_n = ce_n;
      if (pulse) ab_clk = 1'b1;
      @(negedge clk);
      ab_clk = 1'b0;
      @(negedge clk);
      if (le || (!ce_n && pulse)) exp_ab = d;
      #1;
      if (le)             chk("R2 ab follow",  b_io, exp_ab);
      else if (ce_n)      chk("R4 ab inhibit", b_io, exp_ab);
      else if (pulse)     chk("R3 ab capture", b_io, exp_ab);
      else                chk("R5 ab hold",    b_io, exp_ab);
   endtask

   task automatic case_ba(input logic [W-1:0] d, input logic le,
                          input logic ce_n, input logic pulse);
      @(negedge clk);
      tb_b_en = 1'b1; tb_b_val = d;
      ba_le = le; ba_ce_n = ce_n;
      if (pulse) ba_clk = 1'b1;
      @(negedge clk);
      ba_clk = 1'b0;
      @(negedge clk);
      if (le || (!ce_n && pulse)) exp_ba = d;
      #1;
      chk("R7 ba mode sweep", a_io, exp_ba);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst = 1'b1;
      ab_oe_n = 1'b0; ab_le = 1'b0; ab_clk = 1'b0; ab_ce_n = 1'b1;
      ba_oe_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b0; ba_ce_n = 1'b1;
      b_clk_i = 1'b0;
      tb_a_en = 1'b0; tb_b_en = 1'b0; tb_a_val = '0; tb_b_val = '0;
      exp_ab = '0; exp_ba = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      // R1: reset state of both directions
      chk("R1 ab cleared", b_io, '0);
      chk("R9 no flag", {{(W-1){1'b0}}, contention}, '0);
      ab_oe_n = 1'b1; ba_oe_n = 1'b0;
      #1;
      chk("R1 ba cleared", a_io, '0);

      // R2: same-cycle transparency and value kept after le falls
      @(negedge clk);
      ba_oe_n = 1'b1; ab_oe_n = 1'b0;
      tb_a_en = 1'b1; tb_a_val = 17'h0AAAA; ab_le = 1'b1;
      #1;
      chk("R2 transparent", b_io, 17'h0AAAA);
      tb_a_val = 17'h15555;
      #1;
      chk("R2 transparent change", b_io, 17'h15555);
      @(negedge clk);
      ab_le = 1'b0; tb_a_val = 17'h01234;
      @(negedge clk);
      #1;
      chk("R2 le fall keeps last sample", b_io, 17'h15555);

      // R5: clock already high when the gate opens is not an edge
      @(negedge clk);
      ab_ce_n = 1'b1; ab_clk = 1'b1; tb_a_val = 17'h00F0F;
      @(negedge clk);
      ab_ce_n = 1'b0; tb_a_val = 17'h1FFFF;
      repeat (2) @(negedge clk);
      #1;
      chk("R5 high clock no capture", b_io, 17'h15555);
      ab_clk = 1'b0;
      @(negedge clk);
      ab_clk = 1'b1;
      @(negedge clk);
      #1;
      chk("R3 capture after low", b_io, 17'h1FFFF);
      exp_ab = 17'h1FFFF;
      ab_clk = 1'b0; ab_ce_n = 1'b1;

      // R6: released B bus reads back what the bench drives
      @(negedge clk);
      ab_oe_n = 1'b1; tb_b_en = 1'b1; tb_b_val = '0;
      #1;
      chk("R6 b released", b_io, '0);
      tb_b_en = 1'b0; ab_oe_n = 1'b0;
      #1;
      chk("R6 b driven again", b_io, 17'h1FFFF);

      // R8: forwarded clocks
      ab_clk = 1'b1;
      #1;
      chk("R8 b_clk_o high", {{(W-1){1'b0}}, b_clk_o}, 17'h1);
      ab_clk = 1'b0;
      #1;
      chk("R8 b_clk_o low", {{(W-1){1'b0}}, b_clk_o}, 17'h0);
      @(negedge clk);
      ab_oe_n = 1'b1; ba_oe_n = 1'b0; b_clk_i = 1'b1;
      #1;
      chk("R8 a_clk_o high", {{(W-1){1'b0}}, a_clk_o}, 17'h1);
      b_clk_i = 1'b0;
      #1;
      chk("R8 a_clk_o low", {{(W-1){1'b0}}, a_clk_o}, 17'h0);

      // Sweep A to B
      @(negedge clk);
      ba_oe_n = 1'b1; ab_oe_n = 1'b0; tb_b_en = 1'b0;
      for (int i = 0; i < 24; i++) begin
         case_ab(W'(i * 32'h0001_3A5B + 32'h77), ~i[0], i[1], i[2]);
      end

      // Sweep B to A
      @(negedge clk);
      ab_oe_n = 1'b1; ab_le = 1'b0; ab_ce_n = 1'b1;
      tb_a_en = 1'b0; ba_oe_n = 1'b0;
      for (int i = 0; i < 24; i++) begin
         case_ba(W'(i * 32'h0000_B3C7 + 32'h1F01), ~i[0], i[1], i[2]);
      end
      // leave a nonzero word stored in both directions
      case_ba(17'h1ABCD, 1'b1, 1'b1, 1'b0);
      case_ba(17'h1ABCD, 1'b0, 1'b1, 1'b0);

      // R9: both enables low releases both buses
      @(negedge clk);
      ba_le = 1'b0; ba_ce_n = 1'b1;
      tb_a_en = 1'b1; tb_a_val = '0;
      tb_b_en = 1'b1; tb_b_val = '0;
      ab_oe_n = 1'b0; ba_oe_n = 1'b0;
      #1;
      chk("R9 flag set", {{(W-1){1'b0}}, contention}, 17'h1);
      chk("R9 a released", a_io, '0);
      chk("R9 b released", b_io, '0);
      ba_oe_n = 1'b1;
      #1;
      chk("R9 flag clear", {{(W-1){1'b0}}, contention}, 17'h0);

      finish_run();
   end

endmodule